// File: doc/BRIEF.md
# DMA Queue-Pair Channel Control Register Bank

This block holds the software-visible control state for a set of DMA queue-pair channels. Each channel has a submission ring and a completion ring in memory. Software programs the base addresses of both rings and their sizes, advances the submission tail to hand over work, and moves the completion head as it consumes results. A small per-channel state machine decides when the channel is working. It obeys enable, pause and a self-clearing reset, and it shows its condition as a 4-bit state code. Per-channel status and mask registers drive one interrupt line for each channel.

Descriptor fetch and data movement happen elsewhere. While a channel is in its running state, the block shows this on `ch_busy` and presents the submission entry being served on `ch_sq_head`. The engine reports the end of that entry on `eng_done`, or reports a failure on `eng_err`. The block advances its internal submission head, which wraps at the programmed depth. Each depth register holds the number of ring entries minus one.

The bus is a simple 32-bit register port. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. Read data appears one cycle after the request, marked by `bus_rvalid`. Channel `n` occupies the 256-byte window that starts at `n*0x100`. One global mode bit at address 0x217C selects between the two link roles.

Top module: `qpc_regs`

## Requirements
- R1: After reset every ring register, pointer, control bit and status bit reads 0. The mask reads 0x1FFF, the state reads IDLE (0), `ch_busy` and `irq` are low, and `mode_rc` is 0.
- R2: Channel n's registers sit at n*0x100 plus these offsets: submission base low 0x00 and high 0x04, submission depth 0x08, submission tail 0x0C, completion base low 0x10 and high 0x14, completion depth 0x18, completion head 0x1C. Base registers keep 32 bits. Depth and pointer registers keep PTR_W low bits (10 by default), and a read returns them zero-extended.
- R3: If the channel is enabled (offset 0x20 bit 0), not paused (offset 0x20 bit 4), and its tail differs from its internal head, an IDLE channel enters RUN (state code 1 at offset 0x30, bits 3:0). `ch_busy` is high in RUN, and `ch_sq_head` shows the entry being served.
- R4: Each `eng_done` pulse in RUN advances the head by one. The head wraps to 0 after it equals the depth value, where the depth value is the entry count minus 1. Each pulse also sets status bit 0 (offset 0x40). The channel returns to IDLE once the head equals the tail.
- R5: While pause is set or enable is clear, no new entry starts. A RUN channel finishes its current entry and then goes to PAUSE (code 3) if pause is set, or to IDLE if enable is clear. Clearing pause returns a PAUSE channel to IDLE, and the channel resumes from there.
- R6: `eng_err` in RUN moves the channel to ABORT (code 5) and sets status bit 1. The head does not advance.
- R7: Writing 1 to bit 0 at offset 0x24 resets the channel on the next cycle. The tail, the completion head and the internal head become 0, and the state becomes IDLE. The reset bit reads 0 afterwards.
- R8: Status bits (offset 0x40, bits 12:0) clear when 1 is written to them. The mask is at offset 0x44, bits 12:0, and a 1 masks a bit. `irq[n]` is the OR of the status bits that are not masked.
- R9: At address 0x217C, bit 0 selects the mode: 1 is RC and 0 is EP. The bit is readable and drives `mode_rc`.
- R10: `eng_done` and `eng_err` have no effect on a channel that is not in RUN. The head and the status stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| eng_done | input | NUM_CH | Engine finished the current entry of a channel |
| eng_err | input | NUM_CH | Engine failed the current entry of a channel |
| ch_busy | output | NUM_CH | Channel is in RUN |
| ch_sq_head | output | NUM_CH*PTR_W | Internal submission head of each channel, packed |
| irq | output | NUM_CH | Interrupt line for each channel |
| mode_rc | output | 1 | Global mode bit |

## Verification
The hardest case to reach is the head wrapping past the programmed depth while software keeps submitting new work. Only runs that start at various head positions and cross the ring boundary reach it. Seeded random runs do this: each picks a small depth and then submits batches of up to a full ring, so the head crosses the boundary many times, and the head port is compared after every completion. Directed sequences cover pause and disable arriving mid-entry, an error followed by a channel reset, and completion pulses that come when the channel is not running.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    localparam int INT_W        = 13;
    localparam int INT_DONE_BIT = 0;
    localparam int INT_ERR_BIT  = 1;
    localparam int PAGE_LSB     = 8;
    localparam int MODE_ADDR    = 32'h217C;

    localparam logic [7:0] OFS_SQ_LO   = 8'h00;
    localparam logic [7:0] OFS_SQ_HI   = 8'h04;
    localparam logic [7:0] OFS_SQ_DEP  = 8'h08;
    localparam logic [7:0] OFS_SQ_TAIL = 8'h0C;
    localparam logic [7:0] OFS_CQ_LO   = 8'h10;
    localparam logic [7:0] OFS_CQ_HI   = 8'h14;
    localparam logic [7:0] OFS_CQ_DEP  = 8'h18;
    localparam logic [7:0] OFS_CQ_HEAD = 8'h1C;
    localparam logic [7:0] OFS_CTRL_A  = 8'h20;
    localparam logic [7:0] OFS_CTRL_B  = 8'h24;
    localparam logic [7:0] OFS_STATE   = 8'h30;
    localparam logic [7:0] OFS_INT_STS = 8'h40;
    localparam logic [7:0] OFS_INT_MSK = 8'h44;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_PAUSE_BIT = 4;
    localparam int CTRL_RST_BIT   = 0;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_RUN     = 4'd1,
        ST_CPL     = 4'd2,
        ST_PAUSE   = 4'd3,
        ST_HALT    = 4'd4,
        ST_ABORT   = 4'd5,
        ST_WAIT    = 4'd6,
        ST_BUFFCLR = 4'd7
    } ch_state_e;

endpackage

// File: rtl/qpc_decode.sv
module qpc_decode
    import qpc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 14,
    parameter int CH_W   = 2
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_CH-1:0] ch_wr,
    output logic [7:0]        ofs,
    output logic [CH_W-1:0]   ch_sel,
    output logic              ch_hit,
    output logic              mode_hit,
    output logic              mode_wr
);
    localparam int PAGE_W = ADDR_W - PAGE_LSB;

    logic [PAGE_W-1:0] page;

    always_comb begin
        page     = bus_addr[ADDR_W-1:PAGE_LSB];
        ofs      = bus_addr[PAGE_LSB-1:0];
        ch_hit   = (32'(page) < NUM_CH);
        ch_sel   = CH_W'(page);
        mode_hit = (32'(bus_addr) == MODE_ADDR);
        mode_wr  = bus_valid && bus_write && mode_hit;
        for (int i = 0; i < NUM_CH; i++) begin
            ch_wr[i] = bus_valid && bus_write && ch_hit && (32'(page) == i);
        end
    end

endmodule

// File: rtl/qpc_chan.sv
module qpc_chan
    import qpc_pkg::*;
#(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       ofs,
    input  logic [31:0]      wdata,
    input  logic             eng_done,
    input  logic             eng_err,
    output logic [31:0]      rd_word,
    output logic             busy,
    output logic [PTR_W-1:0] sq_head,
    output logic             irq,
    output logic [3:0]       st_o,
    output logic             pause_o,
    output logic             rstp_o,
    output logic             msk0_o
);

    typedef struct packed {
        logic [31:0]      sq_lo;
        logic [31:0]      sq_hi;
        logic [31:0]      cq_lo;
        logic [31:0]      cq_hi;
        logic [PTR_W-1:0] sq_dep;
        logic [PTR_W-1:0] sq_tail;
        logic [PTR_W-1:0] sq_head;
        logic [PTR_W-1:0] cq_dep;
        logic [PTR_W-1:0] cq_head;
        logic             en;
        logic             pause;
        logic             rst_pulse;
        ch_state_e        state;
        logic [INT_W-1:0] sts;
        logic [INT_W-1:0] msk;
    } ch_regs_t;

    ch_regs_t         q, d;
    logic [PTR_W-1:0] head_nxt;

    always_comb begin
        d        = q;
        head_nxt = (q.sq_head == q.sq_dep) ? '0 : q.sq_head + 1'b1;

        d.rst_pulse = 1'b0;

        // register writes from the bus
        if (wr_en) begin
            case (ofs)
                OFS_SQ_LO:   d.sq_lo   = wdata;
                OFS_SQ_HI:   d.sq_hi   = wdata;
                OFS_CQ_LO:   d.cq_lo   = wdata;
                OFS_CQ_HI:   d.cq_hi   = wdata;
                OFS_SQ_DEP:  d.sq_dep  = wdata[PTR_W-1:0];
                OFS_SQ_TAIL: d.sq_tail = wdata[PTR_W-1:0];
                OFS_CQ_DEP:  d.cq_dep  = wdata[PTR_W-1:0];
                OFS_CQ_HEAD: d.cq_head = wdata[PTR_W-1:0];
                OFS_CTRL_A: begin
                    d.en    = wdata[CTRL_EN_BIT];
                    d.pause = wdata[CTRL_PAUSE_BIT];
                end
                OFS_CTRL_B:  d.rst_pulse = wdata[CTRL_RST_BIT];
                OFS_INT_STS: d.sts = q.sts & ~wdata[INT_W-1:0];
                OFS_INT_MSK: d.msk = wdata[INT_W-1:0];
                default: ;
            endcase
        end

        // channel state machine; hardware status set wins over clear
        case (q.state)
            ST_IDLE: begin
                if (q.en && !q.pause && (q.sq_tail != q.sq_head)) begin
                    d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (eng_err) begin
                    d.state            = ST_ABORT;
                    d.sts[INT_ERR_BIT] = 1'b1;
                end else if (eng_done) begin
                    d.sq_head           = head_nxt;
                    d.sts[INT_DONE_BIT] = 1'b1;
                    if (q.pause) begin
                        d.state = ST_PAUSE;
                    end else if (!q.en || (head_nxt == q.sq_tail)) begin
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_PAUSE: begin
                if (!q.pause) begin
                    d.state = ST_IDLE;
                end
            end
            ST_ABORT: ;
            default:  d.state = ST_IDLE;
        endcase

        // self-clearing channel reset, applied one cycle after the write
        if (q.rst_pulse) begin
            d.sq_tail = '0;
            d.cq_head = '0;
            d.sq_head = '0;
            d.state   = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.msk   <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (ofs)
            OFS_SQ_LO:   rd_word = q.sq_lo;
            OFS_SQ_HI:   rd_word = q.sq_hi;
            OFS_CQ_LO:   rd_word = q.cq_lo;
            OFS_CQ_HI:   rd_word = q.cq_hi;
            OFS_SQ_DEP:  rd_word = 32'(q.sq_dep);
            OFS_SQ_TAIL: rd_word = 32'(q.sq_tail);
            OFS_CQ_DEP:  rd_word = 32'(q.cq_dep);
            OFS_CQ_HEAD: rd_word = 32'(q.cq_head);
            OFS_CTRL_A:  rd_word = 32'({q.pause, 3'b000, q.en});
            OFS_CTRL_B:  rd_word = 32'(q.rst_pulse);
            OFS_STATE:   rd_word = 32'(q.state);
            OFS_INT_STS: rd_word = 32'(q.sts);
            OFS_INT_MSK: rd_word = 32'(q.msk);
            default:     rd_word = '0;
        endcase
    end

    assign busy    = (q.state == ST_RUN);
    assign sq_head = q.sq_head;
    assign irq     = |(q.sts & ~q.msk);
    assign st_o    = q.state;
    assign pause_o = q.pause;
    assign rstp_o  = q.rst_pulse;
    assign msk0_o  = q.msk[INT_DONE_BIT];

endmodule

// File: rtl/qpc_regs.sv
module qpc_regs
    import qpc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int PTR_W  = 10,
    parameter int ADDR_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_rvalid,
    input  logic [NUM_CH-1:0]       eng_done,
    input  logic [NUM_CH-1:0]       eng_err,
    output logic [NUM_CH-1:0]       ch_busy,
    output logic [NUM_CH*PTR_W-1:0] ch_sq_head,
    output logic [NUM_CH-1:0]       irq,
    output logic                    mode_rc
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
        logic        mode;
    } top_regs_t;

    logic [NUM_CH-1:0]   ch_wr;
    logic [7:0]          ofs;
    logic [CH_W-1:0]     ch_sel;
    logic                ch_hit;
    logic                mode_hit;
    logic                mode_wr;
    logic [31:0]         rd_word [NUM_CH];
    logic [NUM_CH*4-1:0] st_vec;
    logic [NUM_CH-1:0]   pause_vec;
    logic [NUM_CH-1:0]   rstp_vec;
    logic [NUM_CH-1:0]   msk0_vec;

    top_regs_t q, d;

    qpc_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W)
    ) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .ch_wr     (ch_wr),
        .ofs       (ofs),
        .ch_sel    (ch_sel),
        .ch_hit    (ch_hit),
        .mode_hit  (mode_hit),
        .mode_wr   (mode_wr)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        qpc_chan #(
            .PTR_W (PTR_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ch_wr[g]),
            .ofs      (ofs),
            .wdata    (bus_wdata),
            .eng_done (eng_done[g]),
            .eng_err  (eng_err[g]),
            .rd_word  (rd_word[g]),
            .busy     (ch_busy[g]),
            .sq_head  (ch_sq_head[g*PTR_W +: PTR_W]),
            .irq      (irq[g]),
            .st_o     (st_vec[g*4 +: 4]),
            .pause_o  (pause_vec[g]),
            .rstp_o   (rstp_vec[g]),
            .msk0_o   (msk0_vec[g])
        );
    end

    always_comb begin
        d        = q;
        d.rvalid = bus_valid && !bus_write;
        if (bus_valid && !bus_write) begin
            if (mode_hit) begin
                d.rdata = 32'(q.mode);
            end else if (ch_hit) begin
                d.rdata = rd_word[ch_sel];
            end else begin
                d.rdata = '0;
            end
        end
        if (mode_wr) begin
            d.mode = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata  = q.rdata;
    assign bus_rvalid = q.rvalid;
    assign mode_rc    = q.mode;

endmodule

// File: rtl/qpc_regs_chk.sv
module qpc_regs_chk #(
    parameter int NUM_CH = 4,
    parameter int PTR_W  = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_valid,
    input logic [NUM_CH-1:0]       ch_busy,
    input logic [NUM_CH*PTR_W-1:0] ch_sq_head,
    input logic [NUM_CH-1:0]       eng_done,
    input logic [NUM_CH-1:0]       eng_err,
    input logic [NUM_CH-1:0]       irq,
    input logic [NUM_CH*4-1:0]     st_vec,
    input logic [NUM_CH-1:0]       pause_vec,
    input logic [NUM_CH-1:0]       rstp_vec,
    input logic [NUM_CH-1:0]       msk0_vec
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        p_no_start_paused_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_busy[g] && pause_vec[g]) |=> !ch_busy[g]);

        p_head_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!(ch_busy[g] && eng_done[g]) && !rstp_vec[g])
            |=> $stable(ch_sq_head[g*PTR_W +: PTR_W]));

        p_err_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_busy[g] && eng_err[g] && !rstp_vec[g])
            |=> (st_vec[g*4 +: 4] == 4'd5) && !ch_busy[g]);

        p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_busy[g] && eng_done[g] && !eng_err[g] && !msk0_vec[g] && !bus_valid)
            |=> irq[g]);

        p_rst_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rstp_vec[g] |=> (ch_sq_head[g*PTR_W +: PTR_W] == '0) && (st_vec[g*4 +: 4] == 4'd0));
    end
endmodule

bind qpc_regs qpc_regs_chk #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/qpc_regs_bench.sv
module qpc_regs_bench;
    localparam int NCH = 4;
    localparam int PW  = 10;
    localparam int AW  = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid;
    logic [NCH-1:0]  eng_done = '0;
    logic [NCH-1:0]  eng_err = '0;
    logic [NCH-1:0]  ch_busy;
    logic [NCH*PW-1:0] ch_sq_head;
    logic [NCH-1:0]  irq;
    logic            mode_rc;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int m_head [NCH];

    always #4 clk = ~clk;

    qpc_regs #(.NUM_CH(NCH), .PTR_W(PW), .ADDR_W(AW)) u_qpc_regs (.*);

    function automatic int ra(input int ch, input int ofs);
        return ch * 256 + ofs;
    endfunction

    function automatic int nxt(input int h, input int dep);
        return (h == dep) ? 0 : h + 1;
    endfunction

    function automatic logic [31:0] head_of(input int ch);
        return 32'(ch_sq_head[ch*PW +: PW]);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(a); bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(a);
        @(negedge clk);
        bus_valid = 1'b0;
        v = bus_rdata;
    endtask

    task automatic pulse(input int ch, input bit fail);
        @(negedge clk);
        eng_done[ch] = ~fail; eng_err[ch] = fail;
        @(negedge clk);
        eng_done = '0; eng_err = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pat;
        void'($urandom(32'h5EED));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values
        rd(ra(0, 'h30), v);  check("R1 state", v, 0);
        rd(ra(1, 'h44), v);  check("R1 mask", v, 32'h1FFF);
        rd(ra(2, 'h0C), v);  check("R1 tail", v, 0);
        rd(ra(3, 'h40), v);  check("R1 status", v, 0);
        check("R1 busy", 32'(ch_busy), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 mode", 32'(mode_rc), 0);

        // R2 stride and read-back
        for (int c = 0; c < NCH; c++) begin
            pat = $urandom;
            wr(ra(c, 'h00), pat);        rd(ra(c, 'h00), v); check("R2 sq base lo", v, pat);
            wr(ra(c, 'h14), ~pat);       rd(ra(c, 'h14), v); check("R2 cq base hi", v, ~pat);
            wr(ra(c, 'h18), 32'hFFFF_FFFF); rd(ra(c, 'h18), v); check("R2 cq depth width", v, 32'h3FF);
        end
        rd(ra(0, 'h00), v);
        rd(ra(1, 'h14), pat);
        check("R2 channels distinct", 32'(v == ~pat), 0);

        // R10 done on an idle channel
        pulse(0, 0);
        check("R10 head idle", head_of(0), 0);
        rd(ra(0, 'h40), v); check("R10 status idle", v, 0);

        // R3, R4, R5 pause on channel 1
        wr(ra(1, 'h08), 7);
        wr(ra(1, 'h20), 1);
        wr(ra(1, 'h0C), 2);
        rd(ra(1, 'h30), v); check("R3 run", v, 1);
        check("R3 busy", 32'(ch_busy[1]), 1);
        check("R3 head port", head_of(1), 0);
        wr(ra(1, 'h20), 32'h11);
        pulse(1, 0);
        rd(ra(1, 'h30), v); check("R5 pause state", v, 3);
        check("R5 head after pause", head_of(1), 1);
        check("R5 busy paused", 32'(ch_busy[1]), 0);
        wr(ra(1, 'h20), 1);
        idle(1);
        rd(ra(1, 'h30), v); check("R5 resume", v, 1);
        pulse(1, 0);
        rd(ra(1, 'h30), v); check("R4 idle at tail", v, 0);
        rd(ra(1, 'h40), v); check("R4 done status", v, 1);

        // R5 disable mid entry
        wr(ra(1, 'h0C), 4);
        rd(ra(1, 'h30), v); check("R3 run again", v, 1);
        wr(ra(1, 'h20), 0);
        pulse(1, 0);
        idle(3);
        rd(ra(1, 'h30), v); check("R5 disabled idle", v, 0);
        check("R5 head disabled", head_of(1), 3);
        wr(ra(1, 'h20), 1);
        rd(ra(1, 'h30), v); check("R5 reenable run", v, 1);
        pulse(1, 0);
        check("R4 head 4", head_of(1), 4);

        // R6 error, R10 in abort, R7 reset on channel 2
        wr(ra(2, 'h1C), 2);
        wr(ra(2, 'h08), 3);
        wr(ra(2, 'h20), 1);
        wr(ra(2, 'h0C), 1);
        rd(ra(2, 'h30), v); check("R3 ch2 run", v, 1);
        pulse(2, 1);
        rd(ra(2, 'h30), v); check("R6 abort", v, 5);
        rd(ra(2, 'h40), v); check("R6 err status", v, 2);
        check("R6 head held", head_of(2), 0);
        pulse(2, 0);
        check("R10 head abort", head_of(2), 0);
        rd(ra(2, 'h40), v); check("R10 status abort", v, 2);
        wr(ra(2, 'h24), 1);
        rd(ra(2, 'h24), v); check("R7 self clear", v, 0);
        rd(ra(2, 'h0C), v); check("R7 tail", v, 0);
        rd(ra(2, 'h1C), v); check("R7 cq head", v, 0);
        rd(ra(2, 'h30), v); check("R7 state", v, 0);

        // R8 interrupt on channel 3
        wr(ra(3, 'h08), 1);
        wr(ra(3, 'h20), 1);
        wr(ra(3, 'h0C), 1);
        rd(ra(3, 'h30), v); check("R3 ch3 run", v, 1);
        pulse(3, 0);
        check("R8 masked irq", 32'(irq[3]), 0);
        wr(ra(3, 'h44), 32'h1FFE);
        check("R8 unmasked irq", 32'(irq[3]), 1);
        wr(ra(3, 'h40), 1);
        check("R8 w1c irq", 32'(irq[3]), 0);
        rd(ra(3, 'h40), v); check("R8 w1c status", v, 0);

        // R9 mode register
        rd('h217C, v); check("R9 mode reset", v, 0);
        wr('h217C, 1);
        check("R9 mode out", 32'(mode_rc), 1);
        rd('h217C, v); check("R9 mode read", v, 1);
        wr('h217C, 0);
        check("R9 mode ep", 32'(mode_rc), 0);

        // R4 random batches with wrap
        for (int c = 0; c < NCH; c++) begin
            wr(ra(c, 'h24), 1);
            wr(ra(c, 'h40), 32'h1FFF);
            m_head[c] = 0;
        end
        for (int it = 0; it < 24; it++) begin
            int c, dep, m, tl;
            c = int'($urandom_range(0, NCH - 1));
            if (it < NCH) begin
                dep = int'($urandom_range(1, 6));
                wr(ra(c, 'h24), 1);
                m_head[c] = 0;
                wr(ra(c, 'h08), dep);
                wr(ra(c, 'h20), 1);
            end else begin
                rd(ra(c, 'h08), v);
                dep = int'(v);
                if (dep == 0) begin
                    dep = 3;
                    wr(ra(c, 'h24), 1);
                    m_head[c] = 0;
                    wr(ra(c, 'h08), dep);
                    wr(ra(c, 'h20), 1);
                end
            end
            m  = int'($urandom_range(1, dep));
            tl = m_head[c];
            for (int k = 0; k < m; k++) tl = nxt(tl, dep);
            wr(ra(c, 'h0C), tl);
            rd(ra(c, 'h30), v); check("R3 random run", v, 1);
            for (int k = 0; k < m; k++) begin
                idle(int'($urandom_range(0, 2)));
                pulse(c, 0);
                m_head[c] = nxt(m_head[c], dep);
                check("R4 random head", head_of(c), 32'(m_head[c]));
            end
            rd(ra(c, 'h30), v); check("R4 random idle", v, 0);
            rd(ra(c, 'h40), v); check("R4 random status", v & 32'h1, 1);
            wr(ra(c, 'h40), 1);
        end

        idle(2);
        finish_run();
    end
endmodule